// File: doc/BRIEF.md
# SONET Transmit Scrambler with BIP-8

This block is the byte-serial stage at the end of an STS-3/STM-1 transmit path. Each byte of the outgoing frame enters with a valid flag and, on the first byte of a frame, a start-of-frame flag. The byte leaves one clock later, scrambled by a frame-synchronous keystream. The frame holds ROWS rows of COLS bytes, and the first OH_COLS bytes of every row are transport overhead. The overhead bytes of the first row are sent as they are. Every other byte is XORed with the keystream.

The block also computes an even-parity BIP-8 over each frame as it is sent, which is the XOR of every transmitted byte. That value goes into the B1 slot of the following frame, at row B1_ROW and column B1_COL, and the slot is then scrambled like any other byte. A static control bit turns scrambling off so that the line can be tested. An error-injection path inverts one B1 byte each time a strobe arrives while injection is enabled.

Top module: `sts_tx_scrambler`

## Requirements
- R1: Each byte presented with in_valid=1 appears on out_data exactly one clock later, with out_valid=1. out_sof follows in_sof with the same one-cycle delay. After reset, out_valid is 0 and out_data is 0x00.
- R2: The bytes in columns 0 to OH_COLS-1 of row 0 are passed to the output unchanged.
- R3: The keystream generator implements x^7+x^6+1. Its output bit is the state MSB, and it shifts left with the feedback state[6]^state[5] entering at bit 0. It is loaded with 7'b1111111 for the byte at row 0, column OH_COLS, so that byte is XORed with 0xFE.
- R4: All bytes after that one, including the overhead of rows 1 and up, are XORed with the continuing keystream. The most significant bit comes first, and the state takes eight steps per byte.
- R5: When scr_en=0, every byte except B1 leaves unchanged. The keystream state still advances.
- R6: The byte at row B1_ROW, column B1_COL is replaced by the BIP-8 of the previous frame before scrambling. In the first frame after reset this value is 0x00.
- R7: The BIP-8 is the XOR of all bytes actually transmitted in a frame, from row 0 column 0 to the last byte. This includes a B1 byte that was inverted.
- R8: A one-cycle ber_strobe while b1_err_en=1 is stored and inverts all eight bits of the next B1 byte only. A strobe while b1_err_en=0 has no effect.
- R9: in_sof=1 sets the position to row 0, column 0. Without in_sof, the position wraps to row 0, column 0 after ROWS*COLS valid bytes, and the next frame is processed normally.
- R10: Cycles with in_valid=0 change neither the position, the keystream, the parity nor out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scr_en | input | 1 | 1 = scramble, 0 = test bypass |
| b1_err_en | input | 1 | Enables B1 error injection |
| ber_strobe | input | 1 | One-cycle request to invert the next B1 |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is row 0, column 0 |
| in_data | input | 8 | Unscrambled frame byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte starts a frame |
| out_data | output | 8 | Scrambled frame byte |

## Verification
The bench builds the block with a small frame: ROWS=3, COLS=8, OH_COLS=3 and B1 at row 1, column 0. A frame then holds only 24 bytes. This puts the row-0 overhead boundary, the keystream reload, the B1 substitution and the wrap without a start marker within reach of a few dozen frames. It also exercises the keystream across many row and frame boundaries. Gaps in the input, injected and ignored error strobes, and the bypass mode are each run on their own frames.

// File: rtl/sts_scr_pkg.sv
package sts_scr_pkg;
  localparam int KS_W = 7;
  localparam logic [KS_W-1:0] KS_SEED = 7'h7F;

  // Eight keystream bits, first bit in the MSB of the result.
  function automatic logic [7:0] ks_byte(input logic [KS_W-1:0] s);
    logic [KS_W-1:0] t;
    logic [7:0]      r;
    t = s;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      r[i] = t[6];
      t    = {t[5:0], t[6] ^ t[5]};
    end
    return r;
  endfunction

  // State after eight steps.
  function automatic logic [KS_W-1:0] ks_adv8(input logic [KS_W-1:0] s);
    logic [KS_W-1:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction
endpackage

// File: rtl/sts_frame_pos.sv
module sts_frame_pos #(
  parameter int ROWS    = 9,
  parameter int COLS    = 270,
  parameter int OH_COLS = 9,
  parameter int B1_ROW  = 1,
  parameter int B1_COL  = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic sof,
  output logic row0_oh,
  output logic ks_reload,
  output logic is_b1,
  output logic frame_start
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q, cur_row;
  logic [COL_W-1:0] col_q, cur_col;

  assign cur_row = sof ? '0 : row_q;
  assign cur_col = sof ? '0 : col_q;

  assign frame_start = (cur_row == '0) && (cur_col == '0);
  assign row0_oh     = (cur_row == '0) && (cur_col < COL_W'(OH_COLS));
  assign ks_reload   = (cur_row == '0) && (cur_col == COL_W'(OH_COLS));
  assign is_b1       = (cur_row == ROW_W'(B1_ROW)) && (cur_col == COL_W'(B1_COL));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      if (cur_col == LAST_COL) begin
        col_q <= '0;
        row_q <= (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/sts_scr_key.sv
module sts_scr_key
  import sts_scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       reload,
  input  logic       hold,
  output logic [7:0] key
);
  logic [KS_W-1:0] st_q;

  assign key = reload ? ks_byte(KS_SEED) : ks_byte(st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_SEED;
    end else if (adv) begin
      if (reload)     st_q <= ks_adv8(KS_SEED);
      else if (!hold) st_q <= ks_adv8(st_q);
    end
  end
endmodule

// File: rtl/sts_bip8.sv
module sts_bip8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       frame_start,
  input  logic [7:0] tx_byte,
  output logic [7:0] bip_prev
);
  logic [7:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      bip_prev <= '0;
    end else if (adv) begin
      if (frame_start) begin
        bip_prev <= acc_q;
        acc_q    <= tx_byte;
      end else begin
        acc_q <= acc_q ^ tx_byte;
      end
    end
  end
endmodule

// File: rtl/sts_tx_scrambler.sv
module sts_tx_scrambler #(
  parameter int ROWS    = 9,
  parameter int COLS    = 270,
  parameter int OH_COLS = 9,
  parameter int B1_ROW  = 1,
  parameter int B1_COL  = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scr_en,
  input  logic       b1_err_en,
  input  logic       ber_strobe,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_data
);
  logic       row0_oh, ks_reload, is_b1, frame_start;
  logic [7:0] key, bip_prev, b1_val, src_byte, tx_byte;
  logic       err_pend_q;

  sts_frame_pos #(
    .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS), .B1_ROW(B1_ROW), .B1_COL(B1_COL)
  ) u_pos (
    .clk(clk), .rst(rst), .adv(in_valid), .sof(in_sof),
    .row0_oh(row0_oh), .ks_reload(ks_reload), .is_b1(is_b1), .frame_start(frame_start)
  );

  sts_scr_key u_key (
    .clk(clk), .rst(rst), .adv(in_valid), .reload(ks_reload), .hold(row0_oh), .key(key)
  );

  assign b1_val   = bip_prev ^ {8{err_pend_q}};
  assign src_byte = is_b1 ? b1_val : in_data;
  assign tx_byte  = src_byte ^ ((scr_en && !row0_oh) ? key : 8'h00);

  sts_bip8 u_bip (
    .clk(clk), .rst(rst), .adv(in_valid), .frame_start(frame_start),
    .tx_byte(tx_byte), .bip_prev(bip_prev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pend_q <= 1'b0;
    end else if (in_valid && is_b1) begin
      err_pend_q <= ber_strobe && b1_err_en;
    end else if (ber_strobe && b1_err_en) begin
      err_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid && in_sof;
      if (in_valid) out_data <= tx_byte;
    end
  end
endmodule

// File: rtl/sts_tx_scrambler_chk.sv
module sts_tx_scrambler_chk (
  input logic       clk,
  input logic       rst,
  input logic       scr_en,
  input logic       in_valid,
  input logic       in_sof,
  input logic [7:0] in_data,
  input logic       is_b1,
  input logic       out_valid,
  input logic       out_sof,
  input logic [7:0] out_data
);
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follow_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_sof_follow_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> out_sof);
  assert_oh_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (out_data == $past(in_data)));
  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scr_en && !is_b1) |=> (out_data == $past(in_data)));
  assert_gap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

bind sts_tx_scrambler sts_tx_scrambler_chk u_chk (
  .clk(clk), .rst(rst), .scr_en(scr_en), .in_valid(in_valid), .in_sof(in_sof),
  .in_data(in_data), .is_b1(is_b1), .out_valid(out_valid), .out_sof(out_sof),
  .out_data(out_data)
);

// File: tb/sts_tx_scrambler_bench.sv
module sts_tx_scrambler_bench;
  localparam int ROWS = 3, COLS = 8, OH = 3, B1R = 1, B1C = 0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, scr_en = 1'b1, b1_err_en = 1'b0, ber_strobe = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sof;
  logic [7:0] out_data;

  sts_tx_scrambler #(.ROWS(ROWS), .COLS(COLS), .OH_COLS(OH), .B1_ROW(B1R), .B1_COL(B1C))
  u_sts_tx_scrambler (
    .clk(clk), .rst(rst), .scr_en(scr_en), .b1_err_en(b1_err_en), .ber_strobe(ber_strobe),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  int total = 0, bad = 0;
  logic [8:0] q_exp[$];
  string      q_tag[$];

  // reference model
  int m_row = 0, m_col = 0;
  logic [6:0] m_st = 7'h7F;
  logic [7:0] m_acc = 8'h00, m_hold = 8'h00;
  bit m_pend = 0;
  string body_tag = "R4";
  string b1_tag = "R6";

  task automatic kstep(inout logic [6:0] st, output logic [7:0] k);
    for (int b = 7; b >= 0; b--) begin
      k[b] = st[6];
      st   = {st[5:0], st[6] ^ st[5]};
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit sof, input int gap);
    logic [7:0] src, k, e, dummy;
    string tag;
    if (sof) begin m_row = 0; m_col = 0; end
    tag = body_tag;
    src = d;
    if (m_row == B1R && m_col == B1C) begin
      src = m_hold ^ (m_pend ? 8'hFF : 8'h00);
      m_pend = 0;
      tag = b1_tag;
    end
    if (m_row == 0 && m_col < OH) begin
      k = 8'h00; tag = "R2";
    end else if (m_row == 0 && m_col == OH) begin
      k = 8'hFE; m_st = 7'h7F; kstep(m_st, dummy); tag = "R3";
    end else begin
      kstep(m_st, k);
    end
    e = src ^ (scr_en ? k : 8'h00);
    if (!scr_en && tag == "R4") tag = "R5";
    if (m_row == 0 && m_col == 0) begin m_hold = m_acc; m_acc = e; end
    else m_acc = m_acc ^ e;
    q_exp.push_back({sof, e});
    q_tag.push_back(tag);
    in_valid = 1'b1; in_sof = sof; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    if (m_col == COLS - 1) begin
      m_col = 0;
      m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
    end else m_col++;
  endtask

  task automatic frame(input int seed, input bit sof, input int gap);
    for (int i = 0; i < ROWS * COLS; i++)
      send(8'((i * 37 + seed * 11 + 5) & 255), sof && (i == 0), gap);
  endtask

  task automatic ber(input bit en);
    b1_err_en = en; ber_strobe = 1'b1;
    @(posedge clk); #1;
    ber_strobe = 1'b0;
    if (en) m_pend = 1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_exp.size() == 0) begin
        check(0, "R1 unexpected byte", {out_sof, out_data}, 9'h000);
      end else begin
        logic [8:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({out_sof, out_data} === e, t, {out_sof, out_data}, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 8'h00, "R1 reset", {out_valid, out_data}, 9'h000);
    @(posedge clk); #1;

    frame(1, 1, 0);                      // R2 R3 R4 R6 first frame B1 = 0
    body_tag = "R10"; frame(2, 1, 2);    // R10 idle gaps between bytes
    body_tag = "R4";
    ber(0); b1_tag = "R8"; frame(3, 1, 0);   // R8 strobe while disabled ignored
    ber(1); frame(4, 1, 0);                  // R8 next B1 inverted
    b1_err_en = 1'b0;
    b1_tag = "R7"; frame(5, 1, 0);           // R7 parity covers inverted B1
    b1_tag = "R6";
    scr_en = 1'b0; frame(6, 1, 1);           // R5 bypass
    scr_en = 1'b1; frame(7, 1, 0);
    body_tag = "R9"; frame(8, 0, 0);         // R9 wrap without sof
    body_tag = "R4"; frame(9, 1, 0);
    frame(10, 1, 0);

    repeat (4) @(posedge clk);
    #1;
    check(q_exp.size() == 0, "R1 drain", 9'(q_exp.size()), 9'h000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule